// File: doc/BRIEF.md
# Masked Change-Detect Interrupt Controller

This block merges two event sources into one active-low interrupt request. The first source is a vector of asynchronous real-time status bits. Each bit passes through a synchroniser and is then compared with a baseline copy taken at the last status read. Any unmasked difference, whether the bit rose or fell, requests an interrupt. The second source is a single-cycle "new transmit data" strobe. It only counts while its arm input is high.

Each source keeps its own sticky pending flag. The status flag stays set until a status-register read strobe arrives. The transmit-data flag stays set until a transmit-data read strobe arrives. Either flag is also cleared by a hardware reset or a synchronous software reset. The processor bus is reduced to those two read strobes, plus a read-data port that returns the synchronised status vector.

The pin can either drive both levels or act as an open-drain pull-down. It is presented as a level plus an output enable, so the pad logic outside can build either form.

Top module: `chg_irq_ctrl`

## Requirements
- R1: With `od_mode` = 0 (push-pull), `irq_oe_o` is 1 at all times, and `irq_n_o` is 0 exactly while either pending flag is set and 1 otherwise.
- R2: With `od_mode` = 1 (open-drain), `irq_n_o` is 0 at all times, and `irq_oe_o` is 1 exactly while either pending flag is set (drive low) and 0 otherwise (released).
- R3: A change of an unmasked `stat_in` bit in either direction raises the interrupt. The new input level, held from before a rising clock edge, shows at the outputs after the third rising edge and not after the second (two synchroniser stages plus the pending register).
- R4: A `stat_mask` bit of 1 stops that status bit from raising the interrupt. Clearing the mask bit later raises nothing for changes made while it was masked.
- R5: Once the status flag is set, it stays set until `rd_stat` is sampled high. This holds even if the responsible bit is masked or returns to its old level in the meantime.
- R6: A cycle with `rd_stat` high clears the status flag at that clock edge and takes the current synchronised status as the new baseline. `stat_rdata` always shows the synchronised status vector.
- R7: If a status bit is about to change in the same cycle as a clearing `rd_stat`, the interrupt stays asserted with no released cycle.
- R8: A `txd_new` pulse with `txd_arm` = 1 sets the transmit-data flag at the next edge. With `txd_arm` = 0 the pulse is ignored.
- R9: `rd_txd` clears only the transmit-data flag, and `rd_stat` clears only the status flag. A `txd_new` pulse in the same cycle as `rd_txd` leaves the flag set.
- R10: `soft_rst` clears both flags at the next edge and re-baselines the status, so steady inputs raise nothing afterwards. After hardware reset (`rst_n` low) the pin is released, and a status bit already at 1 when reset ends counts as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset strobe |
| stat_in | input | NBITS | Asynchronous real-time status bits |
| stat_mask | input | NBITS | Per-bit mask, 1 blocks the bit |
| rd_stat | input | 1 | Status-register read strobe |
| stat_rdata | output | NBITS | Synchronised status value returned by the read |
| txd_new | input | 1 | New transmit data event strobe |
| txd_arm | input | 1 | Arms the transmit-data interrupt |
| rd_txd | input | 1 | Transmit-data read strobe |
| od_mode | input | 1 | 0 push-pull, 1 open-drain |
| irq_n_o | output | 1 | Interrupt pin level, active low |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with its defaults: eight status bits and two synchroniser stages. Eight bits allow mask patterns that mix masked and unmasked bits. They also allow a single vector to hold rising and falling changes together. The two-stage depth fixes the three-edge latency, so the bench can sample both the edge before the interrupt appears and the edge at which it appears. It can also place a read exactly in the cycle where a change sits between the two synchroniser stages, to show that no event is lost.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic {
    PIN_PUSHPULL  = 1'b0,
    PIN_OPENDRAIN = 1'b1
  } pin_mode_e;

  typedef struct packed {
    logic lvl;
    logic oe;
  } pin_drive_t;

  // sticky flag update: a set in the same cycle as a clear wins
  function automatic logic next_pend(input logic pend, input logic clr, input logic set);
    return (pend & ~clr) | set;
  endfunction

  // pin value for an active-low request in the chosen mode
  function automatic pin_drive_t pin_value(input pin_mode_e mode, input logic active);
    pin_drive_t d;
    if (mode == PIN_OPENDRAIN) begin
      d.lvl = 1'b0;
      d.oe  = active;
    end else begin
      d.lvl = ~active;
      d.oe  = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], d};
  end

  assign q     = chain_q[LAST];
  assign q_nxt = chain_q[LAST-1];
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det
  import irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [W-1:0] sync,
  input  logic [W-1:0] sync_nxt,
  input  logic [W-1:0] mask,
  input  logic         rd,
  output logic         stat_pend_o,
  output logic         now_hit_o,
  output logic         rd_hit_o
);
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;
  logic         pend_q;
  logic         hit;

  function automatic logic [W-1:0] masked_diff(input logic [W-1:0] a, input logic [W-1:0] b,
                                               input logic [W-1:0] m);
    return (a ^ b) & ~m;
  endfunction

  // masked bits keep following the input so unmasking finds no stale difference
  for (genvar i = 0; i < W; i++) begin : g_snap
    assign snap_d[i] = (srst | rd | mask[i]) ? sync[i] : snap_q[i];
  end

  assign now_hit_o = |masked_diff(sync, snap_q, mask);
  assign rd_hit_o  = |masked_diff(sync_nxt, sync, mask);
  assign hit       = rd ? rd_hit_o : now_hit_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      pend_q <= 1'b0;
    end else begin
      snap_q <= snap_d;
      pend_q <= srst ? 1'b0 : next_pend(pend_q, rd, hit);
    end
  end

  assign stat_pend_o = pend_q;

  p_hold_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !rd && !srst |=> pend_q);
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !srst && !rd_hit_o |=> !pend_q);
  p_rd_race_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !srst && rd_hit_o |=> pend_q);
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && !rd && !srst && !now_hit_o |=> !pend_q);
endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic evt,
  input  logic arm,
  input  logic clr,
  output logic set_o,
  output logic pend_o
);
  logic pend_q;

  assign set_o = evt & arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= srst ? 1'b0 : next_pend(pend_q, clr, set_o);
  end

  assign pend_o = pend_q;

  p_arm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt && arm && !srst |=> pend_q);
  p_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && !srst && !(evt && arm) |=> !pend_q);
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
  import irq_pkg::*;
(
  input  pin_mode_e mode,
  input  logic      active,
  output logic      lvl_o,
  output logic      oe_o
);
  pin_drive_t drv;

  assign drv   = pin_value(mode, active);
  assign lvl_o = drv.lvl;
  assign oe_o  = drv.oe;
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NBITS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [NBITS-1:0] stat_in,
  input  logic [NBITS-1:0] stat_mask,
  input  logic             rd_stat,
  output logic [NBITS-1:0] stat_rdata,
  input  logic             txd_new,
  input  logic             txd_arm,
  input  logic             rd_txd,
  input  logic             od_mode,
  output logic             irq_n_o,
  output logic             irq_oe_o
);
  localparam int STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NBITS-1:0] stat_sync;
  logic [NBITS-1:0] stat_sync_nxt;
  logic             stat_pend;
  logic             txd_pend;
  logic             stat_now_hit;
  logic             stat_rd_hit;
  logic             txd_set;
  logic             irq_act;

  irq_sync #(.W(NBITS), .STAGES(STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (stat_in),
    .q     (stat_sync),
    .q_nxt (stat_sync_nxt)
  );

  irq_chg_det #(.W(NBITS)) i_chg (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst        (soft_rst),
    .sync        (stat_sync),
    .sync_nxt    (stat_sync_nxt),
    .mask        (stat_mask),
    .rd          (rd_stat),
    .stat_pend_o (stat_pend),
    .now_hit_o   (stat_now_hit),
    .rd_hit_o    (stat_rd_hit)
  );

  irq_evt_latch i_txd (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst   (soft_rst),
    .evt    (txd_new),
    .arm    (txd_arm),
    .clr    (rd_txd),
    .set_o  (txd_set),
    .pend_o (txd_pend)
  );

  assign irq_act    = stat_pend | txd_pend;
  assign stat_rdata = stat_sync;

  irq_pin_drv i_pin (
    .mode   (pin_mode_e'(od_mode)),
    .active (irq_act),
    .lvl_o  (irq_n_o),
    .oe_o   (irq_oe_o)
  );

  p_pp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !od_mode && !stat_pend && !txd_pend |-> irq_n_o && irq_oe_o);
  p_od_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    od_mode && (stat_pend || txd_pend) |-> irq_oe_o && !irq_n_o);
  p_srst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !stat_pend && !txd_pend);
  p_txd_survives_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !soft_rst && txd_pend && !rd_txd |=> txd_pend);
  p_stat_survives_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_txd && !soft_rst && stat_pend && !rd_stat |=> stat_pend);
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_act && !stat_now_hit && !stat_rd_hit && !txd_set |=> !irq_act);
endmodule

// File: tb/test_chg_irq_ctrl.sv
`timescale 1ns/100ps
module test_chg_irq_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         soft_rst = 1'b0;
  logic [W-1:0] stat_in = '0;
  logic [W-1:0] stat_mask = '0;
  logic         rd_stat = 1'b0;
  logic [W-1:0] stat_rdata;
  logic         txd_new = 1'b0;
  logic         txd_arm = 1'b0;
  logic         rd_txd = 1'b0;
  logic         od_mode = 1'b0;
  logic         irq_n_o;
  logic         irq_oe_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chg_irq_ctrl #(.NBITS(W), .SYNC_STAGES(2)) i_chg_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stat_in(stat_in),
    .stat_mask(stat_mask), .rd_stat(rd_stat), .stat_rdata(stat_rdata),
    .txd_new(txd_new), .txd_arm(txd_arm), .rd_txd(rd_txd), .od_mode(od_mode),
    .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
  );

  // {status, mask, open-drain}
  localparam logic [16:0] VEC [10] = '{
    {8'h01, 8'h00, 1'b0}, {8'h01, 8'h00, 1'b1}, {8'h03, 8'h02, 1'b0},
    {8'h00, 8'h00, 1'b1}, {8'h80, 8'h7F, 1'b0}, {8'h8F, 8'h0F, 1'b1},
    {8'h0F, 8'h80, 1'b0}, {8'hF0, 8'h00, 1'b1}, {8'hA5, 8'h5A, 1'b0},
    {8'hA5, 8'hFF, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected pin pair {oe, level} for a request state in the current mode
  task automatic chk_irq(input string req, input string what, input bit want);
    logic [1:0] e;
    e = od_mode ? {want, 1'b0} : {1'b1, ~want};
    chk(req, what, {30'd0, irq_oe_o, irq_n_o}, {30'd0, e});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_stat;
    rd_stat = 1'b1;
    @(negedge clk);
    rd_stat = 1'b0;
  endtask

  task automatic read_txd;
    rd_txd = 1'b1;
    @(negedge clk);
    rd_txd = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    logic [W-1:0] prev;
    logic [16:0]  v;
    bit           want;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk_irq("R10", "released after reset", 1'b0);
    chk("R10", "rdata after reset", {24'd0, stat_rdata}, 32'd0);

    prev = '0;
    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      stat_in   = v[16:9];
      stat_mask = v[8:1];
      od_mode   = v[0];
      want = |((stat_in ^ prev) & ~stat_mask);
      cyc(2);
      chk_irq("R3", "not before third edge", 1'b0);
      cyc(1);
      chk_irq(od_mode ? "R2" : "R1", "vector result", want);
      chk("R6", "rdata shows synced status", {24'd0, stat_rdata}, {24'd0, stat_in});
      read_stat();
      chk_irq("R6", "cleared by read", 1'b0);
      prev = stat_in;
    end

    // R4: change while masked, then unmask
    od_mode = 1'b0;
    stat_mask = 8'h04;
    stat_in = stat_in ^ 8'h04;
    cyc(4);
    chk_irq("R4", "masked change", 1'b0);
    stat_mask = 8'h00;
    cyc(4);
    chk_irq("R4", "after unmask", 1'b0);
    chk("R4", "rdata tracks masked bit", {24'd0, stat_rdata}, {24'd0, stat_in});

    // R5: sticky through masking and reversal
    stat_in = stat_in ^ 8'h08;
    cyc(3);
    chk_irq("R5", "raised", 1'b1);
    stat_mask = 8'h08;
    cyc(6);
    chk_irq("R5", "held after mask", 1'b1);
    stat_in = stat_in ^ 8'h08;
    cyc(4);
    chk_irq("R5", "held after reversal", 1'b1);
    read_stat();
    chk_irq("R5", "cleared by read", 1'b0);
    stat_mask = 8'h00;
    cyc(4);
    chk_irq("R5", "quiet after unmask", 1'b0);

    // R7: change in flight during clearing read
    stat_in = stat_in ^ 8'h01;
    cyc(3);
    chk_irq("R7", "first change", 1'b1);
    stat_in = stat_in ^ 8'h02;
    @(negedge clk);
    read_stat();
    chk_irq("R7", "no gap after racing read", 1'b1);
    cyc(1);
    chk_irq("R7", "still raised", 1'b1);
    read_stat();
    chk_irq("R7", "second read clears", 1'b0);

    // R8: arm gating
    txd_arm = 1'b0;
    txd_new = 1'b1;
    @(negedge clk);
    txd_new = 1'b0;
    chk_irq("R8", "unarmed event ignored", 1'b0);
    txd_arm = 1'b1;
    txd_new = 1'b1;
    @(negedge clk);
    txd_new = 1'b0;
    chk_irq("R8", "armed event", 1'b1);

    // R9: independent clears
    read_stat();
    chk_irq("R9", "status read keeps txd", 1'b1);
    stat_in = stat_in ^ 8'h10;
    cyc(3);
    read_txd();
    chk_irq("R9", "txd read keeps status", 1'b1);
    read_stat();
    chk_irq("R9", "both cleared", 1'b0);
    txd_new = 1'b1;
    @(negedge clk);
    txd_new = 1'b1;
    rd_txd = 1'b1;
    @(negedge clk);
    txd_new = 1'b0;
    rd_txd = 1'b0;
    chk_irq("R9", "event beats read", 1'b1);
    read_txd();
    chk_irq("R9", "txd cleared", 1'b0);

    // R10: software reset
    od_mode = 1'b1;
    txd_new = 1'b1;
    @(negedge clk);
    txd_new = 1'b0;
    stat_in = stat_in ^ 8'h20;
    cyc(3);
    chk_irq("R10", "both pending", 1'b1);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk_irq("R10", "soft reset clears", 1'b0);
    cyc(4);
    chk_irq("R10", "no interrupt from steady levels", 1'b0);

    // R10: hardware reset with a bit already high
    od_mode = 1'b0;
    rst_n = 1'b0;
    stat_in = 8'h3C;
    cyc(2);
    rst_n = 1'b1;
    chk_irq("R10", "released at reset exit", 1'b0);
    cyc(3);
    chk_irq("R10", "high bit counts as change", 1'b1);
    read_stat();
    chk_irq("R10", "cleared after read", 1'b0);

    summary();
  end
endmodule